// File: doc/BRIEF.md
# SPI Transfer Buffer and Status Unit

This block sits between a simple register-style data port and a serial shift engine. Software writes frames into a small staging area. Once the programmed group size (one to four frames) has been collected and the transmit buffer is empty, the whole group moves into the transmit buffer. The engine takes frames from the transmit buffer one at a time with a load strobe. Received frames come back through a strobe into a single receive holding register, and software reads them through the same data port.

The unit produces three status flags that follow hardware state: transmit-empty, receive-full and idle. It also keeps four sticky error flags that software can clear: overload, underload, parity error and mode fault. Four interrupt outputs gate these flags with per-source enables. A read-target select makes the data port return the head of the transmit buffer instead of the receive register, so software can inspect what is queued.

Top module: `spi_xfer_buf`

## Requirements
- R1: After reset, fl_txe is 1, fl_rxf is 0, fl_idle is 1 (when eng_busy is 0), all fl_err bits are 0, and rd_data and eng_tx_data are zero.
- R2: frame_lvl value N sets a group size of N+1 frames. Staged frames move to the transmit buffer one cycle after the staging count reaches the group size, provided the transmit buffer is empty. The frames leave the buffer in write order.
- R3: A write is accepted if the staging count is below the group size, or in a cycle in which a forward happens (the write then becomes the first frame of the next group). Any other write is dropped.
- R4: fl_txe is 1 exactly when the transmit buffer holds no frame. It drops after a forward, and it rises right after the engine loads the last frame, even while eng_busy is still 1.
- R5: eng_tx_data shows the head frame of the transmit buffer (zero when the buffer is empty), and each eng_load advances to the next frame. An eng_load while the buffer is empty sets the underload flag, fl_err[1].
- R6: A stored received frame sets fl_rxf. A data read with rd_sel_tx=0 clears it, unless a new frame is stored in the same cycle.
- R7: A frame that arrives while fl_rxf is 1, with no same-cycle receive read, is dropped. The previous frame is kept and the overload flag, fl_err[0], is set.
- R8: A received frame marked with eng_rx_perr sets the parity flag, fl_err[2], whether or not the frame is stored.
- R9: An eng_mode_fault strobe sets the mode-fault flag, fl_err[3].
- R10: The error flags hold until a clear. clr_err bit k clears fl_err bit k (0 overload, 1 underload, 2 parity, 3 mode fault), and a set in the same cycle wins over the clear.
- R11: With rd_sel_tx=1, rd_data returns the transmit buffer head (zero if empty). Reads in this mode leave fl_rxf and the transmit buffer unchanged.
- R12: fl_idle is 1 exactly when eng_busy is 0, the transmit buffer is empty and no frame is staged.
- R13: irq_err is ie_err AND (overload OR underload OR parity); mode fault does not drive it. irq_txe, irq_rxf and irq_idle are their flags gated by ie_txe, ie_rxf and ie_idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_lvl | input | LVL_W | Group size minus one |
| rd_sel_tx | input | 1 | Data read target: 0 receive register, 1 transmit head |
| ie_err | input | 1 | Error interrupt enable |
| ie_txe | input | 1 | Transmit-empty interrupt enable |
| ie_rxf | input | 1 | Receive-full interrupt enable |
| ie_idle | input | 1 | Idle interrupt enable |
| wr_en | input | 1 | Data write strobe |
| wr_data | input | DATA_W | Data written |
| rd_en | input | 1 | Data read strobe |
| rd_data | output | DATA_W | Data read value |
| clr_err | input | 4 | Error flag clear mask |
| eng_load | input | 1 | Engine takes one frame for shifting |
| eng_tx_data | output | DATA_W | Frame offered to the engine |
| eng_busy | input | 1 | Engine is shifting |
| eng_rx_valid | input | 1 | Engine delivers a received frame |
| eng_rx_data | input | DATA_W | Received frame |
| eng_rx_perr | input | 1 | Received frame failed parity |
| eng_mode_fault | input | 1 | Engine detected a mode fault |
| fl_txe | output | 1 | Transmit buffer empty |
| fl_rxf | output | 1 | Receive register full |
| fl_idle | output | 1 | Nothing pending and engine idle |
| fl_err | output | 4 | Sticky errors: overload, underload, parity, mode fault |
| irq_err | output | 1 | Error interrupt |
| irq_txe | output | 1 | Transmit-empty interrupt |
| irq_rxf | output | 1 | Receive-full interrupt |
| irq_idle | output | 1 | Idle interrupt |

## Verification
The assertions check the per-cycle rules on every cycle. These are: underload after a load from an empty buffer, receive-full cleared by a receive read, an overload that leaves the held frame untouched, error flags that stay set until cleared, transmit-target reads that leave receive-full alone, idle implying an empty buffer, and a mode fault that never raises the error interrupt. Group release order, write dropping while staging is full, and data integrity through the transmit buffer depend on longer histories. Only the bench scenarios show these, by comparing every output each cycle with a frame-queue model across all four group sizes and random interleavings.

// File: rtl/spi_xfer_buf_pkg.sv
package spi_xfer_buf_pkg;
   localparam int ERR_N = 4;
   typedef enum int {
      ERR_OVR  = 0,
      ERR_UDR  = 1,
      ERR_PERR = 2,
      ERR_MODF = 3
   } err_idx_e;
endpackage

// File: rtl/spi_xfer_buf_tx.sv
module spi_xfer_buf_tx #(
   parameter int DATA_W     = 32,
   parameter int MAX_FRAMES = 4,
   parameter int LVL_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [LVL_W-1:0]  frame_lvl,
   input  logic              eng_load,
   output logic [DATA_W-1:0] head_data,
   output logic              tx_empty,
   output logic              stage_empty,
   output logic              underrun
);
   localparam int CNT_W = $clog2(MAX_FRAMES + 1);
   localparam int IDX_W = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1;

   logic [DATA_W-1:0] stage_mem [MAX_FRAMES];
   logic [DATA_W-1:0] tx_mem    [MAX_FRAMES];
   logic [CNT_W-1:0]  stage_cnt, tx_cnt, group_len;
   logic [IDX_W-1:0]  tx_rd, wr_idx;
   logic              fwd, wr_ok, pop;

   // group size, clamped to the storage depth
   always_comb begin
      int glen;
      glen = int'(frame_lvl) + 1;
      if (glen > MAX_FRAMES) glen = MAX_FRAMES;
      group_len = CNT_W'(glen);
   end

   assign fwd    = (stage_cnt >= group_len) && (tx_cnt == '0);
   assign wr_ok  = wr_en && (fwd || (stage_cnt < group_len));
   assign wr_idx = fwd ? '0 : IDX_W'(stage_cnt);
   assign pop    = eng_load && (tx_cnt != '0);

   genvar gi;
   generate
      for (gi = 0; gi < MAX_FRAMES; gi++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stage_mem[gi] <= '0;
               tx_mem[gi]    <= '0;
            end else begin
               if (wr_ok && (wr_idx == IDX_W'(gi))) stage_mem[gi] <= wr_data;
               if (fwd) tx_mem[gi] <= stage_mem[gi];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage_cnt <= '0;
         tx_cnt    <= '0;
         tx_rd     <= '0;
      end else begin
         if (fwd) stage_cnt <= wr_ok ? CNT_W'(1) : '0;
         else if (wr_ok) stage_cnt <= stage_cnt + CNT_W'(1);
         if (fwd) begin
            tx_cnt <= stage_cnt;
            tx_rd  <= '0;
         end else if (pop) begin
            tx_cnt <= tx_cnt - CNT_W'(1);
            tx_rd  <= tx_rd + IDX_W'(1);
         end
      end
   end

   assign tx_empty    = (tx_cnt == '0);
   assign stage_empty = (stage_cnt == '0);
   assign head_data   = tx_empty ? '0 : tx_mem[tx_rd];
   assign underrun    = eng_load && tx_empty;
endmodule

// File: rtl/spi_xfer_buf_rx.sv
module spi_xfer_buf_rx #(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              rx_perr,
   input  logic              rd_take,
   output logic [DATA_W-1:0] rx_q,
   output logic              rx_full,
   output logic              ovr_ev,
   output logic              perr_ev
);
   logic store;

   assign ovr_ev  = rx_valid && rx_full && !rd_take;
   assign store   = rx_valid && !ovr_ev;
   assign perr_ev = rx_valid && rx_perr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q    <= '0;
         rx_full <= 1'b0;
      end else begin
         if (store) begin
            rx_q    <= rx_data;
            rx_full <= 1'b1;
         end else if (rd_take) begin
            rx_full <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/spi_xfer_buf_flags.sv
module spi_xfer_buf_flags
   import spi_xfer_buf_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [ERR_N-1:0] set_ev,
   input  logic [ERR_N-1:0] clr_mask,
   input  logic             txe,
   input  logic             rxf,
   input  logic             idle,
   input  logic             ie_err,
   input  logic             ie_txe,
   input  logic             ie_rxf,
   input  logic             ie_idle,
   output logic [ERR_N-1:0] err_q,
   output logic             irq_err,
   output logic             irq_txe,
   output logic             irq_rxf,
   output logic             irq_idle
);
   genvar gk;
   generate
      for (gk = 0; gk < ERR_N; gk++) begin : g_err
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            err_q[gk] <= 1'b0;
            else if (set_ev[gk])   err_q[gk] <= 1'b1;
            else if (clr_mask[gk]) err_q[gk] <= 1'b0;
         end
      end
   endgenerate

   assign irq_err  = ie_err && (err_q[ERR_OVR] || err_q[ERR_UDR] || err_q[ERR_PERR]);
   assign irq_txe  = ie_txe && txe;
   assign irq_rxf  = ie_rxf && rxf;
   assign irq_idle = ie_idle && idle;
endmodule

// File: rtl/spi_xfer_buf.sv
module spi_xfer_buf
   import spi_xfer_buf_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int MAX_FRAMES = 4,
   parameter int LVL_W      = (MAX_FRAMES > 1) ? $clog2(MAX_FRAMES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LVL_W-1:0]  frame_lvl,
   input  logic              rd_sel_tx,
   input  logic              ie_err,
   input  logic              ie_txe,
   input  logic              ie_rxf,
   input  logic              ie_idle,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   input  logic [3:0]        clr_err,
   input  logic              eng_load,
   output logic [DATA_W-1:0] eng_tx_data,
   input  logic              eng_busy,
   input  logic              eng_rx_valid,
   input  logic [DATA_W-1:0] eng_rx_data,
   input  logic              eng_rx_perr,
   input  logic              eng_mode_fault,
   output logic              fl_txe,
   output logic              fl_rxf,
   output logic              fl_idle,
   output logic [3:0]        fl_err,
   output logic              irq_err,
   output logic              irq_txe,
   output logic              irq_rxf,
   output logic              irq_idle
);
   generate
      if (DATA_W < 4)        begin : g_bad_width  $error("DATA_W below 4"); end
      if (MAX_FRAMES < 1)    begin : g_bad_depth  $error("MAX_FRAMES below 1"); end
      if (ERR_N != 4)        begin : g_bad_errn   $error("error vector must be 4 wide"); end
   endgenerate

   logic [DATA_W-1:0] head_data, rx_hold;
   logic              stage_empty, underrun, ovr_ev, perr_ev, rd_take;
   logic [ERR_N-1:0]  set_ev;

   assign rd_take = rd_en && !rd_sel_tx;

   spi_xfer_buf_tx #(
      .DATA_W(DATA_W), .MAX_FRAMES(MAX_FRAMES), .LVL_W(LVL_W)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .frame_lvl(frame_lvl), .eng_load(eng_load), .head_data(head_data),
      .tx_empty(fl_txe), .stage_empty(stage_empty), .underrun(underrun)
   );

   spi_xfer_buf_rx #(.DATA_W(DATA_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .rx_valid(eng_rx_valid), .rx_data(eng_rx_data),
      .rx_perr(eng_rx_perr), .rd_take(rd_take), .rx_q(rx_hold),
      .rx_full(fl_rxf), .ovr_ev(ovr_ev), .perr_ev(perr_ev)
   );

   always_comb begin
      set_ev           = '0;
      set_ev[ERR_OVR]  = ovr_ev;
      set_ev[ERR_UDR]  = underrun;
      set_ev[ERR_PERR] = perr_ev;
      set_ev[ERR_MODF] = eng_mode_fault;
   end

   assign fl_idle = !eng_busy && fl_txe && stage_empty;

   spi_xfer_buf_flags u_flags (
      .clk(clk), .rst_n(rst_n), .set_ev(set_ev), .clr_mask(clr_err),
      .txe(fl_txe), .rxf(fl_rxf), .idle(fl_idle),
      .ie_err(ie_err), .ie_txe(ie_txe), .ie_rxf(ie_rxf), .ie_idle(ie_idle),
      .err_q(fl_err), .irq_err(irq_err), .irq_txe(irq_txe),
      .irq_rxf(irq_rxf), .irq_idle(irq_idle)
   );

   assign eng_tx_data = head_data;
   assign rd_data     = rd_sel_tx ? head_data : rx_hold;
endmodule

// File: rtl/spi_xfer_buf_chk.sv
module spi_xfer_buf_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              rd_en,
   input logic              rd_sel_tx,
   input logic [3:0]        clr_err,
   input logic              eng_load,
   input logic              eng_busy,
   input logic              eng_rx_valid,
   input logic              fl_txe,
   input logic              fl_rxf,
   input logic              fl_idle,
   input logic [3:0]        fl_err,
   input logic              irq_err,
   input logic [DATA_W-1:0] rx_hold
);
   a_r5_underload_on_empty_load: assert property (@(posedge clk) disable iff (!rst_n)
      eng_load && fl_txe |=> fl_err[1]);

   a_r6_read_clears_full: assert property (@(posedge clk) disable iff (!rst_n)
      fl_rxf && rd_en && !rd_sel_tx && !eng_rx_valid |=> !fl_rxf);

   a_r7_overload_keeps_frame: assert property (@(posedge clk) disable iff (!rst_n)
      fl_rxf && eng_rx_valid && !(rd_en && !rd_sel_tx) |=> fl_err[0] && $stable(rx_hold));

   a_r10_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      fl_err[0] && !clr_err[0] |=> fl_err[0]);

   a_r11_tx_read_keeps_full: assert property (@(posedge clk) disable iff (!rst_n)
      fl_rxf && rd_en && rd_sel_tx |=> fl_rxf);

   a_r12_idle_implies_empty: assert property (@(posedge clk) disable iff (!rst_n)
      fl_idle |-> fl_txe && !eng_busy);

   a_r13_modf_no_err_irq: assert property (@(posedge clk) disable iff (!rst_n)
      fl_err[3] && (fl_err[2:0] == 3'b000) |-> !irq_err);
endmodule

bind spi_xfer_buf spi_xfer_buf_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/spi_xfer_buf_tb.sv
`timescale 1ns/1ps
module spi_xfer_buf_tb;
   localparam int DW = 32;
   localparam int NCYC = 20000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    frame_lvl = '0;
   logic          rd_sel_tx = 0, ie_err = 0, ie_txe = 0, ie_rxf = 0, ie_idle = 0;
   logic          wr_en = 0, rd_en = 0, eng_load = 0, eng_busy = 0;
   logic          eng_rx_valid = 0, eng_rx_perr = 0, eng_mode_fault = 0;
   logic [DW-1:0] wr_data = '0, eng_rx_data = '0;
   logic [3:0]    clr_err = '0;
   logic [DW-1:0] rd_data, eng_tx_data;
   logic          fl_txe, fl_rxf, fl_idle, irq_err, irq_txe, irq_rxf, irq_idle;
   logic [3:0]    fl_err;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #2 clk = ~clk;

   spi_xfer_buf u_dut (.*);

   // reference model state
   logic [DW-1:0] m_stage[$], m_tx[$];
   logic [DW-1:0] m_rx;
   logic          m_rxf;
   logic [3:0]    m_err;

   function automatic int glen_of(input logic [1:0] l);
      return int'(l) + 1;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_stage = {}; m_tx = {}; m_rx = '0; m_rxf = 0; m_err = '0;
      end else begin
         bit fwd, take, ovr, udr;
         logic [3:0] setv;
         fwd = (m_stage.size() >= glen_of(frame_lvl)) && (m_tx.size() == 0);
         udr = eng_load && (m_tx.size() == 0);
         if (eng_load && m_tx.size() > 0) void'(m_tx.pop_front());
         if (fwd) begin m_tx = m_stage; m_stage = {}; end
         if (wr_en && (fwd || m_stage.size() < glen_of(frame_lvl))) m_stage.push_back(wr_data);
         take = rd_en && !rd_sel_tx;
         ovr = eng_rx_valid && m_rxf && !take;
         if (eng_rx_valid && !ovr) begin m_rx = eng_rx_data; m_rxf = 1; end
         else if (take) m_rxf = 0;
         setv = {eng_mode_fault, eng_rx_valid && eng_rx_perr, udr, ovr};
         m_err = (m_err & ~clr_err) | setv;
      end
   end

   task automatic chk(input string req, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic check_all();
      logic [DW-1:0] head;
      bit mt;
      mt   = (m_tx.size() == 0);
      head = mt ? '0 : m_tx[0];
      chk("R4",  "fl_txe",  DW'(fl_txe), DW'(mt));
      chk("R5",  "eng_tx_data", eng_tx_data, head);
      chk("R6",  "fl_rxf",  DW'(fl_rxf), DW'(m_rxf));
      chk("R7",  "overload", DW'(fl_err[0]), DW'(m_err[0]));
      chk("R5",  "underload", DW'(fl_err[1]), DW'(m_err[1]));
      chk("R8",  "parity",  DW'(fl_err[2]), DW'(m_err[2]));
      chk("R9",  "modefault", DW'(fl_err[3]), DW'(m_err[3]));
      if (rd_sel_tx) chk("R11", "rd_data tx", rd_data, head);
      else           chk("R6",  "rd_data rx", rd_data, m_rx);
      chk("R12", "fl_idle", DW'(fl_idle), DW'(!eng_busy && mt && m_stage.size() == 0));
      chk("R13", "irq_err", DW'(irq_err), DW'(ie_err && (m_err[0] || m_err[1] || m_err[2])));
      chk("R13", "irq_txe", DW'(irq_txe), DW'(ie_txe && mt));
      chk("R13", "irq_rxf", DW'(irq_rxf), DW'(ie_rxf && m_rxf));
      chk("R13", "irq_idle", DW'(irq_idle), DW'(ie_idle && !eng_busy && mt && m_stage.size() == 0));
   endtask

   task automatic idle_inputs();
      wr_en = 0; rd_en = 0; eng_load = 0; eng_rx_valid = 0;
      eng_rx_perr = 0; eng_mode_fault = 0; clr_err = '0;
   endtask

   // one cycle: check outputs, then apply the next stimulus
   task automatic step();
      @(negedge clk);
      check_all();
   endtask

   task automatic write(input logic [DW-1:0] d);
      step(); idle_inputs(); wr_en = 1; wr_data = d;
   endtask

   task automatic load();
      step(); idle_inputs(); eng_load = 1;
   endtask

   task automatic rx(input logic [DW-1:0] d, input bit p);
      step(); idle_inputs(); eng_rx_valid = 1; eng_rx_data = d; eng_rx_perr = p;
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_fail++;
         $display("FAIL R1 watchdog: actual running expected finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1: reset state
      chk("R1", "txe", DW'(fl_txe), 1);
      chk("R1", "rxf", DW'(fl_rxf), 0);
      chk("R1", "idle", DW'(fl_idle), 1);
      chk("R1", "err", DW'(fl_err), 0);
      chk("R1", "eng_tx_data", eng_tx_data, 0);
      // R2/R3: group of 3 frames, extra write dropped while waiting
      frame_lvl = 2'd2;
      write(32'hA1); write(32'hA2);
      eng_busy = 1;
      load();                    // R5: underload on empty buffer
      write(32'hA3);
      step(); idle_inputs();
      chk("R2", "txe still set before forward", DW'(fl_txe), 1);
      step(); idle_inputs();
      chk("R2", "group forwarded", eng_tx_data, 32'hA1);
      write(32'hB1); write(32'hB2); write(32'hB3);
      write(32'hB4);             // R3: staging full, dropped
      load(); load(); load();    // R4: txe rises after last load while busy
      step(); idle_inputs();
      chk("R4", "txe after last load", DW'(fl_txe), 1);
      step(); idle_inputs();
      chk("R3", "next group head", eng_tx_data, 32'hB1);
      load(); load(); load();
      eng_busy = 0;
      // R7/R8: overload keeps first frame, parity on dropped frame
      rx(32'h11, 0); rx(32'h22, 1);
      step(); idle_inputs();
      chk("R7", "held frame", rd_data, 32'h11);
      chk("R8", "parity on dropped", DW'(fl_err[2]), 1);
      // R11: transmit-target read leaves rxf
      rd_sel_tx = 1; rd_en = 1;
      step(); idle_inputs(); rd_sel_tx = 0;
      chk("R11", "rxf kept", DW'(fl_rxf), 1);
      // R9/R10: mode fault then clear all with simultaneous set of overload
      eng_mode_fault = 1;
      step(); idle_inputs();
      clr_err = 4'hF; eng_rx_valid = 1; eng_rx_data = 32'h33;
      step(); idle_inputs();
      chk("R10", "set wins", DW'(fl_err), 4'b0001);
      rd_en = 1;                 // R6: read clears rxf
      step(); idle_inputs(); clr_err = 4'hF;
      chk("R6", "rxf cleared", DW'(fl_rxf), 0);
      step(); idle_inputs();

      // constrained random phase
      for (int c = 0; c < NCYC; c++) begin
         step();
         wr_en          = ($urandom % 100) < 30;
         wr_data        = $urandom;
         rd_en          = ($urandom % 100) < 20;
         rd_sel_tx      = ($urandom % 100) < 20;
         eng_load       = ($urandom % 100) < 18;
         eng_busy       = ($urandom % 100) < 50;
         eng_rx_valid   = ($urandom % 100) < 20;
         eng_rx_data    = $urandom;
         eng_rx_perr    = ($urandom % 100) < 10;
         eng_mode_fault = ($urandom % 100) < 3;
         clr_err        = (($urandom % 100) < 10) ? 4'($urandom) : 4'h0;
         if ((c % 500) == 0) frame_lvl = 2'($urandom);
         if ((c % 64) == 0) begin
            ie_err = 1'($urandom); ie_txe = 1'($urandom);
            ie_rxf = 1'($urandom); ie_idle = 1'($urandom);
         end
      end
      step();
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule